// File: doc/BRIEF.md
# Serial Boot Configuration Loader

This block collects a processor's boot-time operating modes from a slow serial source such as a small EPROM or a piece of glue logic. While the power-good input is high, it divides the master clock down to a serial clock output. On each rising edge of that serial clock it takes in one bit. After a fixed number of bits it latches the low part of the captured word into a configuration register and raises a done flag.

The configuration register is decoded into named settings: output driver strength, timer-interrupt disable, system bus width, write protocol, byte order, clock multiplier and writeback data-rate code. A configuration error flag reports bits that must be zero but are set, and reserved codes. Once capture ends, the serial clock keeps running but the serial input is ignored. Dropping power-good restarts the whole sequence.

Top module: `bootcfg_loader`

## Requirements
- R1: `ser_clk` has a period of DIV master clocks (default 256), is high for the second half of each period, and keeps toggling after `done` is set.
- R2: While `pwr_ok` is high, `ser_in` is sampled once on each rising edge of `ser_clk`. Exactly NBITS bits (default 256) are taken. The first bit becomes bit 0 of the mode word and the last becomes bit NBITS-1.
- R3: `done` rises one master clock after the NBITS-th sample and stays high while `pwr_ok` stays high.
- R4: After `done`, changes on `ser_in` have no effect on any decoded output.
- R5: Bits 14:13 set `drive_pct`: 2'b10 gives 100, 2'b11 gives 83, 2'b00 gives 67 and 2'b01 gives 50.
- R6: Bit 12 drives `bus_is32` (1 means a 32-bit bus), bit 11 drives `tmr_int_off`, bits 10:9 appear unchanged on `wr_mode`, and bit 8 drives `big_endian` (1 means big endian).
- R7: Bits 7:5 hold a multiplier code c. For c from 0 to 6, `clk_mult` = c+2. Code 7 is reserved and gives `clk_mult` = 0.
- R8: Bits 4:1 appear unchanged on `wb_code`. Codes 0 to 8 are valid and 9 to 15 are reserved.
- R9: `cfg_err` is 1 only when `done` is 1 and at least one of these holds: bit 0 is set, any of bits NBITS-1:15 is set, the multiplier code is 7, or `wb_code` is above 8.
- R10: While `pwr_ok` is low, the divider, bit count, `done` and configuration are held cleared and `ser_clk` is low. When `pwr_ok` rises again, a fresh capture starts.
- R11: After a synchronous reset, `done`, `cfg_err` and `ser_clk` are 0, `drive_pct` is 67 and `clk_mult` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Power-good; high enables capture |
| ser_in | input | 1 | Serial mode bit from the external source |
| ser_clk | output | 1 | Divided serial clock |
| done | output | 1 | Capture complete |
| cfg_err | output | 1 | Must-be-zero bit set or reserved code captured |
| drive_pct | output | 7 | Output driver strength in percent |
| tmr_int_off | output | 1 | Timer interrupt disabled |
| bus_is32 | output | 1 | 1 = 32-bit system bus, 0 = 64-bit |
| wr_mode | output | 2 | Write protocol code |
| big_endian | output | 1 | 1 = big endian |
| clk_mult | output | 4 | Clock multiplier value (0 for the reserved code) |
| wb_code | output | 4 | Writeback data-rate code |

## Verification
The assertions assume that `ser_in` is steady around each rising edge of `ser_clk`. They also assume that `pwr_ok` changes only between master clock edges and is not resynchronised by the block. The stimulus therefore changes `ser_in` one master clock after each falling edge of `ser_clk`, which is half a serial period before the next sample, and changes `pwr_ok` on falling master clock edges. Random mode words are built with fields both inside and outside their legal ranges. Directed words place single set bits at the first, last and boundary positions of the stream.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

    // Driver strength encoding (bits 14:13 of the mode word)
    typedef enum logic [1:0] {
        DRV_67  = 2'b00,
        DRV_50  = 2'b01,
        DRV_100 = 2'b10,
        DRV_83  = 2'b11
    } drive_code_e;

    localparam int LOW_BITS      = 15;
    localparam logic [3:0] WB_MAX = 4'd8;
    localparam logic [2:0] MULT_RSV = 3'd7;

    typedef struct packed {
        logic        high_nz;  // any bit above the low field set
        logic        bus32;    // bit 12
        logic        tmr_off;  // bit 11
        drive_code_e drv;      // bits 14:13
        logic [1:0]  wr;       // bits 10:9
        logic        be;       // bit 8
        logic [2:0]  mult;     // bits 7:5
        logic [3:0]  wb;       // bits 4:1
        logic        rsv0;     // bit 0
    } mode_t;

    function automatic mode_t unpack_low(input logic [LOW_BITS-1:0] b, input logic hi);
        mode_t m;
        m.high_nz = hi;
        m.drv     = drive_code_e'(b[14:13]);
        m.bus32   = b[12];
        m.tmr_off = b[11];
        m.wr      = b[10:9];
        m.be      = b[8];
        m.mult    = b[7:5];
        m.wb      = b[4:1];
        m.rsv0    = b[0];
        return m;
    endfunction

    function automatic logic [6:0] pct_of(input drive_code_e d);
        case (d)
            DRV_100: return 7'd100;
            DRV_83:  return 7'd83;
            DRV_67:  return 7'd67;
            default: return 7'd50;
        endcase
    endfunction

    function automatic logic [3:0] mult_of(input logic [2:0] c);
        if (c == MULT_RSV) return 4'd0;
        return {1'b0, c} + 4'd2;
    endfunction

    function automatic logic mode_bad(input mode_t m);
        return m.rsv0 | m.high_nz | (m.mult == MULT_RSV) | (m.wb > WB_MAX);
    endfunction

endpackage

// File: rtl/bootcfg_clkdiv.sv
module bootcfg_clkdiv #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ser_clk,
    output logic tick
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            ser_clk <= 1'b0;
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
            if (cnt == CW'(HALF - 1))
                ser_clk <= 1'b1;
            else if (cnt == CW'(DIV - 1))
                ser_clk <= 1'b0;
        end
    end

    // High for the master edge on which ser_clk rises
    assign tick = run && (cnt == CW'(HALF - 1));

endmodule

// File: rtl/bootcfg_shifter.sv
module bootcfg_shifter #(
    parameter int NBITS = 256,
    parameter int CNTW  = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             ser_in,
    output logic [NBITS-1:0] word,
    output logic [CNTW-1:0]  bit_cnt,
    output logic             full
);
    assign full = (bit_cnt == CNTW'(NBITS));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bit_cnt <= '0;
            word    <= '0;
        end else if (tick && !full) begin
            word    <= {ser_in, word[NBITS-1:1]};   // first bit ends at index 0
            bit_cnt <= bit_cnt + CNTW'(1);
        end
    end

endmodule

// File: rtl/bootcfg_decode.sv
module bootcfg_decode
    import bootcfg_pkg::*;
#(
    parameter int NBITS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             full,
    input  logic [NBITS-1:0] word,
    output logic             done,
    output mode_t            mode
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            done <= 1'b0;
            mode <= '0;
        end else if (full && !done) begin
            done <= 1'b1;
            mode <= unpack_low(word[LOW_BITS-1:0], |word[NBITS-1:LOW_BITS]);
        end
    end

endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
    import bootcfg_pkg::*;
#(
    parameter int DIV   = 256,
    parameter int NBITS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       ser_in,
    output logic       ser_clk,
    output logic       done,
    output logic       cfg_err,
    output logic [6:0] drive_pct,
    output logic       tmr_int_off,
    output logic       bus_is32,
    output logic [1:0] wr_mode,
    output logic       big_endian,
    output logic [3:0] clk_mult,
    output logic [3:0] wb_code
);
    localparam int CNTW = $clog2(NBITS + 1);

    logic             tick;
    logic             full;
    logic [NBITS-1:0] word;
    logic [CNTW-1:0]  bit_cnt;
    mode_t            mode;

    bootcfg_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .run(pwr_ok), .ser_clk(ser_clk), .tick(tick)
    );

    bootcfg_shifter #(.NBITS(NBITS), .CNTW(CNTW)) u_shift (
        .clk(clk), .rst(rst), .run(pwr_ok), .tick(tick), .ser_in(ser_in),
        .word(word), .bit_cnt(bit_cnt), .full(full)
    );

    bootcfg_decode #(.NBITS(NBITS)) u_dec (
        .clk(clk), .rst(rst), .run(pwr_ok), .full(full), .word(word),
        .done(done), .mode(mode)
    );

    assign drive_pct   = pct_of(mode.drv);
    assign tmr_int_off = mode.tmr_off;
    assign bus_is32    = mode.bus32;
    assign wr_mode     = mode.wr;
    assign big_endian  = mode.be;
    assign clk_mult    = mult_of(mode.mult);
    assign wb_code     = mode.wb;
    assign cfg_err     = done && mode_bad(mode);

endmodule

// File: rtl/bootcfg_loader_chk.sv
module bootcfg_loader_chk #(
    parameter int NBITS = 256,
    parameter int CNTW  = $clog2(NBITS + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            pwr_ok,
    input logic            ser_clk,
    input logic            done,
    input logic            cfg_err,
    input logic [6:0]      drive_pct,
    input logic            tmr_int_off,
    input logic            bus_is32,
    input logic [1:0]      wr_mode,
    input logic            big_endian,
    input logic [3:0]      clk_mult,
    input logic [3:0]      wb_code,
    input logic [CNTW-1:0] bit_cnt
);
    logic [20:0] outs;
    assign outs = {drive_pct, tmr_int_off, bus_is32, wr_mode, big_endian, clk_mult, wb_code};

    p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (!ser_clk && !done && bit_cnt == '0));

    p_done_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (done && pwr_ok) |=> done);

    p_done_count_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (bit_cnt == CNTW'(NBITS)));

    p_sample_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt == $past(bit_cnt) + CNTW'(1)) |-> $rose(ser_clk));

    p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (done && pwr_ok) |=> $stable(outs));

    p_err_gate_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> done);

    p_mult_range_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_err) |-> (clk_mult >= 4'd2 && clk_mult <= 4'd8));

    p_pct_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (drive_pct == 7'd100 || drive_pct == 7'd83 || drive_pct == 7'd67 || drive_pct == 7'd50));

endmodule

bind bootcfg_loader bootcfg_loader_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ser_clk(ser_clk), .done(done),
    .cfg_err(cfg_err), .drive_pct(drive_pct), .tmr_int_off(tmr_int_off),
    .bus_is32(bus_is32), .wr_mode(wr_mode), .big_endian(big_endian),
    .clk_mult(clk_mult), .wb_code(wb_code), .bit_cnt(bit_cnt)
);

// File: tb/bootcfg_loader_tb.sv
module bootcfg_loader_tb;
    localparam int DIV   = 8;
    localparam int NBITS = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0;
    logic ser_in = 1'b0;
    logic       ser_clk, done, cfg_err, tmr_int_off, bus_is32, big_endian;
    logic [6:0] drive_pct;
    logic [1:0] wr_mode;
    logic [3:0] clk_mult, wb_code;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bootcfg_loader #(.DIV(DIV), .NBITS(NBITS)) u_dut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ser_in(ser_in), .ser_clk(ser_clk),
        .done(done), .cfg_err(cfg_err), .drive_pct(drive_pct), .tmr_int_off(tmr_int_off),
        .bus_is32(bus_is32), .wr_mode(wr_mode), .big_endian(big_endian),
        .clk_mult(clk_mult), .wb_code(wb_code)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pct(input logic [NBITS-1:0] w);
        case (w[14:13])
            2'b10: return 100;
            2'b11: return 83;
            2'b00: return 67;
            default: return 50;
        endcase
    endfunction

    function automatic int exp_mult(input logic [NBITS-1:0] w);
        return (w[7:5] == 3'd7) ? 0 : int'(w[7:5]) + 2;
    endfunction

    function automatic bit exp_err(input logic [NBITS-1:0] w);
        return w[0] || (|w[NBITS-1:15]) || (w[7:5] == 3'd7) || (w[4:1] > 4'd8);
    endfunction

    function automatic logic [NBITS-1:0] rand_legal();
        logic [NBITS-1:0] w = '0;
        w[14:1] = 14'($urandom);
        w[7:5]  = 3'($urandom % 7);
        w[4:1]  = 4'($urandom % 9);
        return w;
    endfunction

    function automatic logic [NBITS-1:0] rand_any();
        logic [NBITS-1:0] w = '0;
        for (int k = 0; k < NBITS / 32; k++) w[k*32 +: 32] = $urandom;
        if ($urandom % 2) w[NBITS-1:15] = '0;
        return w;
    endfunction

    task automatic check_fields(input logic [NBITS-1:0] w);
        chk(drive_pct == 7'(exp_pct(w)), "R5 drive_pct", drive_pct, exp_pct(w));
        chk(bus_is32 == w[12], "R6 bus_is32", bus_is32, w[12]);
        chk(tmr_int_off == w[11], "R6 tmr_int_off", tmr_int_off, w[11]);
        chk(wr_mode == w[10:9], "R6 wr_mode", wr_mode, w[10:9]);
        chk(big_endian == w[8], "R6 big_endian", big_endian, w[8]);
        chk(clk_mult == 4'(exp_mult(w)), "R7 clk_mult", clk_mult, exp_mult(w));
        chk(wb_code == w[4:1], "R8 wb_code", wb_code, w[4:1]);
        chk(cfg_err == exp_err(w), "R9 cfg_err", cfg_err, exp_err(w));
    endtask

    // Full capture of one word, LSB first, with done timing check
    task automatic load(input logic [NBITS-1:0] w);
        pwr_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ser_clk && !done, "R10 idle while pwr_ok low", {ser_clk, done}, 0);
        ser_in = w[0];
        pwr_ok = 1'b1;
        for (int i = 0; i < NBITS; i++) begin
            ser_in = w[i];
            @(posedge ser_clk);
            if (i < NBITS - 1) begin
                @(negedge ser_clk);
                @(negedge clk);
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R3 done not yet at sample edge", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R3 done one clock after last sample", done, 1);
        check_fields(w);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [NBITS-1:0] w;
        logic [20:0] snap;
        time t0, t1, t2;
        int seed_dummy;
        seed_dummy = $urandom(32'd4650);

        repeat (4) @(negedge clk);
        // R11 reset state
        chk(done == 0 && cfg_err == 0 && ser_clk == 0, "R11 reset flags", {done, cfg_err, ser_clk}, 0);
        chk(drive_pct == 7'd67, "R11 reset drive_pct", drive_pct, 67);
        chk(clk_mult == 4'd2, "R11 reset clk_mult", clk_mult, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(!ser_clk && !done, "R10 no activity without pwr_ok", ser_clk, 0);

        // Directed words: every drive code, fields, LSB-first order
        w = '0; w[14:13] = 2'b10; w[12] = 1; w[7:5] = 3'd6; w[4:1] = 4'd8; load(w);
        w = '0; w[14:13] = 2'b11; w[11] = 1; w[10:9] = 2'b11; load(w);
        w = '0; w[14:13] = 2'b01; w[8] = 1; w[7:5] = 3'd0; load(w);
        w = '0; w[1] = 1; load(w);                       // R2: second bit lands at bit 1
        chk(wb_code == 4'd1, "R2 lsb-first order", wb_code, 1);
        w = '0; w[0] = 1; load(w);                        // R9 bit 0
        w = '0; w[NBITS-1] = 1; load(w);                  // R2/R9 last bit
        chk(cfg_err == 1'b1, "R2 last bit captured as top bit", cfg_err, 1);
        w = '0; w[15] = 1; load(w);                       // R9 lowest must-be-zero
        w = '0; w[7:5] = 3'd7; load(w);                   // R7 reserved multiplier
        w = '0; w[4:1] = 4'd9; load(w);                   // R8/R9 first reserved rate
        w = '0; w[4:1] = 4'd15; w[14:1] = w[14:1] | 14'h1FC0; load(w);

        // R1: serial clock period and duty after capture
        @(posedge ser_clk); t0 = $time;
        @(negedge ser_clk); t1 = $time;
        @(posedge ser_clk); t2 = $time;
        chk((t2 - t0) == DIV * 10, "R1 ser_clk period", (t2 - t0) / 10, DIV);
        chk((t1 - t0) == (DIV / 2) * 10, "R1 ser_clk high time", (t1 - t0) / 10, DIV / 2);

        // R4: input ignored after done
        snap = {drive_pct, tmr_int_off, bus_is32, wr_mode, big_endian, clk_mult, wb_code};
        for (int k = 0; k < 6; k++) begin
            @(negedge ser_clk); @(negedge clk);
            ser_in = ~ser_in;
        end
        @(negedge clk);
        chk(snap == {drive_pct, tmr_int_off, bus_is32, wr_mode, big_endian, clk_mult, wb_code},
            "R4 outputs frozen", {drive_pct, tmr_int_off, bus_is32, wr_mode, big_endian, clk_mult, wb_code}, snap);
        chk(done == 1'b1, "R3 done held", done, 1);

        // R10: drop pwr_ok mid-capture, then capture fresh
        pwr_ok = 1'b0; repeat (2) @(negedge clk);
        w = '0; w[14:13] = 2'b10;
        ser_in = 1'b1; pwr_ok = 1'b1;
        repeat (20) @(posedge ser_clk);
        @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(!done && !ser_clk && !cfg_err, "R10 cleared by pwr_ok drop", {done, ser_clk, cfg_err}, 0);
        chk(clk_mult == 4'd2 && drive_pct == 7'd67, "R10 config cleared", clk_mult, 2);
        load(w);

        // Random words
        for (int n = 0; n < 8; n++) load(rand_legal());
        for (int n = 0; n < 8; n++) load(rand_any());

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule